// File: doc/BRIEF.md
# Three-Bit Dual-Wiring Pseudorandom Sequence Generator

This block is a 3-bit linear feedback shift register that produces a maximal-length pseudorandom sequence of seven nonzero states. A static select input picks one of two feedback wirings of the same polynomial:

- **Outside-feedback form:** the XOR result feeds the first stage.
- **Between-stage form:** the XOR sits between the first and second stages.

Both wirings cycle through all seven nonzero states before they return to the start state.

The register is cleared to the all-ones state by a synchronous active-high reset. A seed can be loaded on any clock edge. The register advances only while the step enable is high. The 3-bit state and a serial bit, taken from the last stage, are both output. A seed of zero is replaced with all ones, so the register can never reach the lock-up state.

Top module: `lfsr3_gen`

## Requirements
- R1: When `rst` is high at a rising edge, `lfsr_q` becomes 3'b111 after that edge, whatever the other inputs are.
- R2: Bit i of `lfsr_q` is stage Q[i]. With `topo_sel`=0 and a step taken, the next state is Q[0]=Q[0]^Q[2], Q[1]=old Q[0] and Q[2]=old Q[1].
- R3: With `topo_sel`=1 and a step taken, the next state is Q[0]=old Q[2], Q[1]=Q[0]^Q[2] and Q[2]=old Q[1].
- R4: Starting from 3'b111 and stepping continuously, each wiring returns to 3'b111 after exactly 7 steps. State 3'b000 never appears.
- R5: When `seed_load` is high (and `rst` is low), `lfsr_q` takes `seed_val` at the edge. This holds even when `step_en` is also high, because the load has priority over the step.
- R6: A load of seed 3'b000 gives 3'b111.
- R7: When `rst`, `seed_load` and `step_en` are all low, `lfsr_q` holds its value.
- R8: `topo_sel` has an effect only at an edge where a step is taken. A change of `topo_sel` while the register holds leaves the state unchanged.
- R9: `ser_o` always equals Q[2], which is `lfsr_q[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, loads 3'b111 |
| seed_load | input | 1 | Load strobe for the seed |
| seed_val | input | 3 | Seed value, where 0 is replaced with all ones |
| step_en | input | 1 | Advance enable |
| topo_sel | input | 1 | Feedback wiring: 0 selects outside-XOR, 1 selects between-stage XOR |
| lfsr_q | output | 3 | Register state, bit i is Q[i] |
| ser_o | output | 1 | Serial pseudorandom bit (Q[2]) |

## Verification
The bench runs each wiring for two full periods from the all-ones start. This separates the two update equations, measures the period and shows that the zero state never appears. Every one of the eight seeds is then loaded and stepped once under each wiring. This exhaustive single-step sweep catches a bit that is miswired only for states the main cycle reaches in a different order, and it shows that the zero seed is replaced. Directed cases cover three further points:

- a load and a step requested on the same edge;
- a hold while `topo_sel` toggles;
- a reset in the middle of a run.

// File: rtl/lfsr3_pkg.sv
package lfsr3_pkg;
  localparam int unsigned ST_W = 3;
  typedef logic [ST_W-1:0] state_t;
  typedef enum logic {TOPO_OUTSIDE = 1'b0, TOPO_BETWEEN = 1'b1} topo_e;
  localparam state_t ALL_ONES = '1;
endpackage

// File: rtl/lfsr3_seed_guard.sv
module lfsr3_seed_guard
  import lfsr3_pkg::*;
(
  input  state_t seed_in,
  output state_t seed_safe
);
  // A zero seed would lock the register; substitute all ones.
  always_comb begin
    if (seed_in == '0) seed_safe = ALL_ONES;
    else               seed_safe = seed_in;
  end
endmodule

// File: rtl/lfsr3_next.sv
module lfsr3_next
  import lfsr3_pkg::*;
(
  input  state_t cur,
  input  logic   topo,
  output state_t nxt
);
  state_t nxt_outside;
  state_t nxt_between;
  logic   fb;

  assign fb = cur[0] ^ cur[ST_W-1];

  // Outside form: the XOR result enters stage 0 and the rest shift up.
  always_comb begin
    nxt_outside = '0;
    nxt_outside[0] = fb;
    for (int i = 1; i < ST_W; i++) nxt_outside[i] = cur[i-1];
  end

  // Between form: the last stage wraps to stage 0, the XOR lands in stage 1.
  always_comb begin
    nxt_between = '0;
    nxt_between[0] = cur[ST_W-1];
    for (int i = 1; i < ST_W; i++) nxt_between[i] = cur[i-1];
    nxt_between[1] = fb;
  end

  assign nxt = (topo == TOPO_BETWEEN) ? nxt_between : nxt_outside;
endmodule

// File: rtl/lfsr3_gen.sv
module lfsr3_gen
  import lfsr3_pkg::*;
#(
  parameter logic [2:0] RESET_SEED = 3'b111
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       seed_load,
  input  logic [2:0] seed_val,
  input  logic       step_en,
  input  logic       topo_sel,
  output logic [2:0] lfsr_q,
  output logic       ser_o
);
  state_t state_r;
  state_t nxt;
  state_t safe_seed;

  lfsr3_seed_guard u_guard (
    .seed_in  (seed_val),
    .seed_safe(safe_seed)
  );

  lfsr3_next u_next (
    .cur (state_r),
    .topo(topo_sel),
    .nxt (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)            state_r <= RESET_SEED;
    else if (seed_load) state_r <= safe_seed;
    else if (step_en)   state_r <= nxt;
  end

  assign lfsr_q = state_r;
  assign ser_o  = state_r[ST_W-1];
endmodule

// File: rtl/lfsr3_gen_chk.sv
module lfsr3_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       seed_load,
  input logic [2:0] seed_val,
  input logic       step_en,
  input logic       topo_sel,
  input logic [2:0] lfsr_q,
  input logic       ser_o
);
  p_reset_seed_r1: assert property (@(posedge clk) rst |=> lfsr_q == 3'b111);

  p_outside_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && step_en && !topo_sel) |=>
      lfsr_q == {$past(lfsr_q[1]), $past(lfsr_q[0]), $past(lfsr_q[0]) ^ $past(lfsr_q[2])});

  p_between_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && step_en && topo_sel) |=>
      lfsr_q == {$past(lfsr_q[1]), $past(lfsr_q[0]) ^ $past(lfsr_q[2]), $past(lfsr_q[2])});

  p_never_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> lfsr_q != 3'b000);

  p_load_seed_r5: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_val != 3'b000) |=> lfsr_q == $past(seed_val));

  p_zero_seed_r6: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_val == 3'b000) |=> lfsr_q == 3'b111);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && !step_en) |=> $stable(lfsr_q));

  p_serial_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ser_o == lfsr_q[2]);
endmodule

bind lfsr3_gen lfsr3_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .seed_load (seed_load),
  .seed_val  (seed_val),
  .step_en   (step_en),
  .topo_sel  (topo_sel),
  .lfsr_q    (lfsr_q),
  .ser_o     (ser_o)
);

// File: tb/lfsr3_gen_tb.sv
module lfsr3_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       seed_load = 1'b0;
  logic [2:0] seed_val = 3'b000;
  logic       step_en = 1'b0;
  logic       topo_sel = 1'b0;
  logic [2:0] lfsr_q;
  logic       ser_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lfsr3_gen dut_i (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_val(seed_val),
    .step_en(step_en), .topo_sel(topo_sel), .lfsr_q(lfsr_q), .ser_o(ser_o)
  );

  // Reference model written from R2/R3; bit i is Q[i].
  function automatic logic [2:0] ref_step(input logic [2:0] s, input logic t);
    logic [2:0] n;
    if (!t) begin
      n[0] = s[0] ^ s[2]; n[1] = s[0]; n[2] = s[1];
    end else begin
      n[0] = s[2]; n[1] = s[0] ^ s[2]; n[2] = s[1];
    end
    return n;
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Apply inputs at the falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_cycle(input logic t, input string req);
    logic [2:0] exp;
    int first_ret;
    exp = 3'b111;
    first_ret = 0;
    topo_sel = t; step_en = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      exp = ref_step(exp, t);
      tick();
      check(req, lfsr_q, exp);
      check("R9", {2'b00, ser_o}, {2'b00, lfsr_q[2]});
      if (lfsr_q == 3'b000) check("R4 zero state", lfsr_q, 3'b001);
      if (lfsr_q == 3'b111 && first_ret == 0) first_ret = k;
    end
    step_en = 1'b0;
    check("R4 period", first_ret[2:0], 3'd7);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    rst = 1'b0;
    check("R1 reset", lfsr_q, 3'b111);
    check("R9", {2'b00, ser_o}, 3'b001);

    run_cycle(1'b0, "R2");

    // R1: reset in mid-run, with a load and a step requested too
    step_en = 1'b1; tick(); tick();
    rst = 1'b1; seed_load = 1'b1; seed_val = 3'b010; tick();
    rst = 1'b0; seed_load = 1'b0; step_en = 1'b0;
    check("R1 midrun", lfsr_q, 3'b111);

    run_cycle(1'b1, "R3");

    // R5: the load wins over the step
    seed_load = 1'b1; step_en = 1'b1; seed_val = 3'b010; tick();
    check("R5", lfsr_q, 3'b010);
    // R6: a zero seed is replaced
    seed_val = 3'b000; tick();
    check("R6", lfsr_q, 3'b111);
    seed_val = 3'b100; tick();
    seed_load = 1'b0; step_en = 1'b0;
    check("R5", lfsr_q, 3'b100);

    // R7/R8: hold while topo_sel toggles
    for (int k = 0; k < 4; k++) begin
      topo_sel = k[0];
      tick();
      check("R7 R8 hold", lfsr_q, 3'b100);
    end
    topo_sel = 1'b1; step_en = 1'b1; tick(); step_en = 1'b0;
    check("R8 sampled at step", lfsr_q, ref_step(3'b100, 1'b1));

    // exhaustive sweep: every seed, both wirings, one step
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s < 8; s++) begin
        logic [2:0] sd;
        sd = (s == 0) ? 3'b111 : s[2:0];
        seed_load = 1'b1; seed_val = s[2:0]; tick();
        seed_load = 1'b0;
        check(s == 0 ? "R6 sweep" : "R5 sweep", lfsr_q, sd);
        topo_sel = t[0]; step_en = 1'b1; tick(); step_en = 1'b0;
        check(t == 0 ? "R2 sweep" : "R3 sweep", lfsr_q, ref_step(sd, t[0]));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule